// File: doc/BRIEF.md
# CEC Message Transmit Controller

This block sends one message on a single-wire, open-drain CEC bus. Software loads the header byte into a one-entry transmit holding register and issues a start command. The block then sends a start bit and shifts out the header. Each byte is followed by an end-of-message bit and an acknowledge slot. Partway through each byte that is not the last, the block raises a byte-request flag. Software answers by loading the next byte, and it marks the final byte by loading it together with the end command.

While it drives the line, the block watches the bus level through a synchronizer. It uses what it sees to detect lost arbitration, foreign drivers (a line error) and acknowledge results. Every outcome is reported as a sticky flag that software clears by writing one. Lost arbitration leaves the start command pending, so the block retries the same message by itself once the bus is high again.

Top module: `cec_tx_ctrl`

## Requirements
- R1: A message opens with a start bit (low for START_LOW cycles, total START_TICKS). Every later bit lasts BIT_TICKS and is a low pulse followed by release. A one is low for ONE_LOW cycles and a zero for ZERO_LOW cycles. Each byte is sent as 8 data bits MSB first, then an end-of-message bit, then an acknowledge slot that is sent as a one.
- R2: The end-of-message bit of a byte is one exactly when that byte was loaded with `tx_eom_i` high. Loading such a byte raises `eom_pending_o`.
- R3: Flag bit 1 (byte request) is raised when the fourth data bit of a byte is complete, and only if that byte is not the last.
- R4: If no next byte is held when a non-final byte's acknowledge slot ends (six bit periods after the request), the block raises flag bit 3 (underrun) and aborts.
- R5: For a directly addressed message (header bits 3:0 not 0xF), a bus that is high at the sample point of an acknowledge slot raises flag bit 5 (acknowledge error) and aborts.
- R6: For a broadcast message (header bits 3:0 equal 0xF), a low bus in an acknowledge slot raises flag bit 5 and aborts. A high bus there is acceptance.
- R7: If the bus reads low at the sample point of a released data bit, outside the header's first four bits, the block raises flag bit 4 (line error) and aborts.
- R8: The block raises flag bit 0 (arbitration lost) in two cases: the bus reads low at the sample point of a released bit among header bits 7:4, or the bus is low when a pending start would begin. It then goes idle, keeps `som_pending_o`, and resends the same header once the bus is high.
- R9: When the final byte's acknowledge slot ends without error, the block raises flag bit 2 (end), clears `som_pending_o` and `eom_pending_o`, and drops `busy_o`.
- R10: Flags are sticky. A one on bit i of `flag_clr_i` clears only flag i, and a new event wins over a clear in the same cycle.
- R11: An underrun, line error or acknowledge error clears both commands. After any abort or lost arbitration, the block releases the bus and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_som_i | input | 1 | Start-of-message command pulse |
| tx_wr_i | input | 1 | Load `tx_byte_i` into the holding register |
| tx_byte_i | input | 8 | Byte to send |
| tx_eom_i | input | 1 | The byte loaded with this strobe is the last one |
| flag_clr_i | input | 6 | Write-one-to-clear for the flags |
| flags_o | output | 6 | Sticky flags: 0 arbitration lost, 1 byte request, 2 end, 3 underrun, 4 line error, 5 acknowledge error |
| som_pending_o | output | 1 | Start command pending |
| eom_pending_o | output | 1 | End command pending |
| busy_o | output | 1 | A message is on the wire |
| cec_line_i | input | 1 | Bus level as read from the pin (1 = high) |
| cec_pull_low_o | output | 1 | Pull the open-drain bus low |

## Verification
The assertions assume that the line level changes only where another driver pulls the bus or the block releases it. They also assume that software loads a byte only while the holding register is free, that is, before the start or after a byte request. The stimulus keeps to these rules. The bench's follower and jammer pull the bus only at the start of one of the block's own pulses and hold it for one zero-length low. Bytes are written right after a request or before a start command. A bus held low while a start is pending is the one idle disturbance the bench uses.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

   typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA} tx_state_e;

   localparam int FLG_W    = 6;
   localparam int FLG_ARB  = 0;
   localparam int FLG_REQ  = 1;
   localparam int FLG_END  = 2;
   localparam int FLG_UDR  = 3;
   localparam int FLG_LINE = 4;
   localparam int FLG_ACK  = 5;

   localparam logic [3:0] SLOT_EOM = 4'd8;
   localparam logic [3:0] SLOT_ACK = 4'd9;
   localparam logic [3:0] REQ_SLOT = 4'd3;
   localparam logic [3:0] ARB_BITS = 4'd4;

   // value carried by slot i of a byte: data MSB first, then EOM, then ack (released)
   function automatic logic slot_bit(input logic [7:0] d, input logic eom, input logic [3:0] i);
      if (i < SLOT_EOM) return d[3'(4'd7 - i)];
      else if (i == SLOT_EOM) return eom;
      else return 1'b1;
   endfunction

endpackage

// File: rtl/cec_tx_bit_timer.sv
module cec_tx_bit_timer #(
   parameter int BIT_TICKS   = 40,
   parameter int ONE_LOW     = 10,
   parameter int ZERO_LOW    = 24,
   parameter int SAMPLE_TICK = 17,
   parameter int START_TICKS = 72,
   parameter int START_LOW   = 56
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic go_start_i,
   input  logic go_val_i,
   input  logic halt_i,
   output logic low_o,
   output logic sample_o,
   output logic done_o
);
   localparam int MAXT = (START_TICKS > BIT_TICKS) ? START_TICKS : BIT_TICKS;
   localparam int CW   = $clog2(MAXT + 1);
   localparam logic [CW-1:0] BIT_LAST   = CW'(BIT_TICKS - 1);
   localparam logic [CW-1:0] START_LAST = CW'(START_TICKS - 1);
   localparam logic [CW-1:0] SMP_AT     = CW'(SAMPLE_TICK - 1);

   generate
      if (!(ONE_LOW > 0 && ONE_LOW < SAMPLE_TICK && SAMPLE_TICK < ZERO_LOW &&
            ZERO_LOW < BIT_TICKS && START_LOW < START_TICKS && START_LOW > ZERO_LOW)) begin : g_bad_timing
         $error("cec_tx_bit_timer: inconsistent bit timing parameters");
      end
   endgenerate

   logic          busy_q, start_q, val_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_c, low_len_c;

   always_comb begin
      last_c    = start_q ? START_LAST : BIT_LAST;
      low_len_c = start_q ? CW'(START_LOW) : (val_q ? CW'(ONE_LOW) : CW'(ZERO_LOW));
   end

   assign done_o   = busy_q && (cnt_q == last_c);
   assign low_o    = busy_q && (cnt_q < low_len_c);
   assign sample_o = busy_q && !start_q && (cnt_q == SMP_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         val_q   <= 1'b0;
         cnt_q   <= '0;
      end else if (go_i) begin
         busy_q  <= 1'b1;
         start_q <= go_start_i;
         val_q   <= go_val_i;
         cnt_q   <= '0;
      end else if (halt_i || done_o) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_LOW_STARTS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_o) |-> $past(go_i)); // R1
   AST_ONE_RELEASED_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o && val_q) |-> !low_o); // R1

endmodule

// File: rtl/cec_tx_flags.sv
module cec_tx_flags #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        f_q <= 1'b0;
            else if (set_i[i]) f_q <= 1'b1;
            else if (clr_i[i]) f_q <= 1'b0;
         end
         assign flags_o[i] = f_q;

         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_o[i]); // R10
         AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]); // R10
      end
   endgenerate
endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
   import cec_tx_pkg::*;
#(
   parameter int BIT_TICKS   = 40,
   parameter int ONE_LOW     = 10,
   parameter int ZERO_LOW    = 24,
   parameter int SAMPLE_TICK = 17,
   parameter int START_TICKS = 72,
   parameter int START_LOW   = 56,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_som_i,
   input  logic             tx_wr_i,
   input  logic [7:0]       tx_byte_i,
   input  logic             tx_eom_i,
   input  logic [FLG_W-1:0] flag_clr_i,
   output logic [FLG_W-1:0] flags_o,
   output logic             som_pending_o,
   output logic             eom_pending_o,
   output logic             busy_o,
   input  logic             cec_line_i,
   output logic             cec_pull_low_o
);
   // ---- line synchronizer variant ----
   logic line_s;
   generate
      if (SYNC_STAGES + ONE_LOW >= SAMPLE_TICK) begin : g_bad_sync
         $error("cec_tx_ctrl: synchronizer latency reaches the sample point");
      end
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line_s = cec_line_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], cec_line_i};
         end
         assign line_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   // ---- state ----
   tx_state_e  st_q;
   logic [3:0] idx_q;
   logic [7:0] sh_byte_q, buf_q;
   logic       cur_eom_q, bcast_q, hdr_q, som_q, eom_q, buf_v_q, buf_eom_q;

   logic t_low, t_smp, t_done;

   // ---- event decode ----
   logic in_idle, start_go, arb_idle, cur_val, smp, ack_slot, clash, arb_win;
   logic arb_wire, line_evt, ack_evt, byte_end, end_evt, udr_evt, next_byte, req_evt;
   logic kill, halt, go, go_val;

   always_comb begin
      in_idle   = (st_q == TX_IDLE);
      start_go  = in_idle && som_q && buf_v_q && line_s;
      arb_idle  = in_idle && som_q && buf_v_q && !line_s;
      cur_val   = slot_bit(sh_byte_q, cur_eom_q, idx_q);
      smp       = t_smp && (st_q == TX_DATA);
      ack_slot  = (idx_q == SLOT_ACK);
      clash     = smp && cur_val && !line_s && !ack_slot;
      arb_win   = hdr_q && (idx_q < ARB_BITS);
      arb_wire  = clash && arb_win;
      line_evt  = clash && !arb_win;
      ack_evt   = smp && ack_slot && (bcast_q ? !line_s : line_s);
      byte_end  = t_done && (st_q == TX_DATA) && ack_slot;
      end_evt   = byte_end && cur_eom_q;
      udr_evt   = byte_end && !cur_eom_q && !buf_v_q;
      next_byte = byte_end && !cur_eom_q && buf_v_q;
      req_evt   = t_done && (st_q == TX_DATA) && (idx_q == REQ_SLOT) && !cur_eom_q;
      kill      = line_evt || ack_evt || udr_evt;
      halt      = kill || arb_wire;
      go        = start_go || (t_done && !end_evt && !udr_evt);
      if (st_q == TX_START) go_val = sh_byte_q[7];
      else if (next_byte)   go_val = buf_q[7];
      else                  go_val = slot_bit(sh_byte_q, cur_eom_q, idx_q + 4'd1);
   end

   cec_tx_bit_timer #(
      .BIT_TICKS(BIT_TICKS), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
      .SAMPLE_TICK(SAMPLE_TICK), .START_TICKS(START_TICKS), .START_LOW(START_LOW)
   ) timer_i (
      .clk(clk), .rst_n(rst_n), .go_i(go), .go_start_i(start_go), .go_val_i(go_val),
      .halt_i(halt), .low_o(t_low), .sample_o(t_smp), .done_o(t_done)
   );

   logic [FLG_W-1:0] flag_set;
   always_comb begin
      flag_set           = '0;
      flag_set[FLG_ARB]  = arb_idle || arb_wire;
      flag_set[FLG_REQ]  = req_evt;
      flag_set[FLG_END]  = end_evt;
      flag_set[FLG_UDR]  = udr_evt;
      flag_set[FLG_LINE] = line_evt;
      flag_set[FLG_ACK]  = ack_evt;
   end

   cec_tx_flags #(.N(FLG_W)) flags_i (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr_i), .flags_o(flags_o)
   );

   // ---- commands and holding register ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         som_q <= 1'b0; eom_q <= 1'b0;
         buf_q <= '0; buf_v_q <= 1'b0; buf_eom_q <= 1'b0;
      end else begin
         if (kill || end_evt)  som_q <= 1'b0;
         else if (cmd_som_i)   som_q <= 1'b1;
         if (kill || end_evt)            eom_q <= 1'b0;
         else if (tx_wr_i && tx_eom_i)   eom_q <= 1'b1;
         if (arb_wire) begin
            buf_q <= sh_byte_q; buf_v_q <= 1'b1; buf_eom_q <= cur_eom_q;
         end else if (kill) begin
            buf_v_q <= 1'b0;
         end else if (tx_wr_i) begin
            buf_q <= tx_byte_i; buf_v_q <= 1'b1; buf_eom_q <= tx_eom_i;
         end else if (start_go || next_byte) begin
            buf_v_q <= 1'b0;
         end
      end
   end

   // ---- sequencer ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= TX_IDLE; idx_q <= '0; sh_byte_q <= '0;
         cur_eom_q <= 1'b0; bcast_q <= 1'b0; hdr_q <= 1'b0;
      end else begin
         unique case (st_q)
            TX_IDLE: if (start_go) begin
               st_q      <= TX_START;
               sh_byte_q <= buf_q;
               cur_eom_q <= buf_eom_q;
               bcast_q   <= (buf_q[3:0] == 4'hF);
               hdr_q     <= 1'b1;
               idx_q     <= '0;
            end
            TX_START: if (t_done) begin
               st_q  <= TX_DATA;
               idx_q <= '0;
            end
            TX_DATA: if (halt || end_evt || udr_evt) begin
               st_q <= TX_IDLE;
            end else if (next_byte) begin
               idx_q     <= '0;
               sh_byte_q <= buf_q;
               cur_eom_q <= buf_eom_q;
               hdr_q     <= 1'b0;
            end else if (t_done) begin
               idx_q <= idx_q + 4'd1;
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign busy_o         = (st_q != TX_IDLE);
   assign cec_pull_low_o = t_low;
   assign som_pending_o  = som_q;
   assign eom_pending_o  = eom_q;

   AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cec_pull_low_o |-> busy_o); // R1
   AST_REQ_MIDBYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[FLG_REQ]) |-> busy_o); // R3
   AST_ARB_KEEPS_SOM: assert property (@(posedge clk) disable iff (!rst_n)
      arb_wire |=> (som_pending_o && !busy_o)); // R8
   AST_END_CLEARS_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt |=> (!som_pending_o && !eom_pending_o && !busy_o)); // R9
   AST_ABORT_CLEARS_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!som_pending_o && !eom_pending_o)); // R11
   AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (kill || arb_wire) |=> (!cec_pull_low_o && !busy_o)); // R11

endmodule

// File: tb/cec_tx_ctrl_tb_top.sv
module cec_tx_ctrl_tb_top;
   localparam int ONE_LOW = 10;
   localparam int ZERO_LOW = 24;
   localparam int START_LOW = 56;
   localparam int THRESH = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_som = 1'b0, tx_wr = 1'b0, tx_eom = 1'b0;
   logic [7:0] tx_byte = '0;
   logic [5:0] flag_clr = '0;
   logic [5:0] flags;
   logic som_p, eom_p, busy, pull_low, line;
   logic other_low = 1'b0;

   int checks = 0, bad = 0;
   int pcount = 0, seen = 0, plen = 0, p_last = 0, hold = 0, start_len = 0;
   int jam_at = -1, ack_mode = 0;
   logic force_low = 1'b0, prev_low = 1'b0;
   logic [7:0] cap [4];
   logic [3:0] cap_eom = '0;

   always #2 clk = ~clk;

   assign line = !(pull_low || other_low);

   cec_tx_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_som_i(cmd_som), .tx_wr_i(tx_wr), .tx_byte_i(tx_byte),
      .tx_eom_i(tx_eom), .flag_clr_i(flag_clr), .flags_o(flags), .som_pending_o(som_p),
      .eom_pending_o(eom_p), .busy_o(busy), .cec_line_i(line), .cec_pull_low_o(pull_low)
   );

   // bus monitor, follower and jammer
   always @(negedge clk) begin
      if (!busy) pcount = 0;
      if (pull_low && !prev_low) begin
         p_last = pcount;
         pcount = pcount + 1;
         plen = 1;
         if (p_last >= 1 && ((p_last - 1) % 10) == 9) begin
            if (ack_mode == 1 || (ack_mode == 2 && ((p_last - 1) / 10) >= 1)) hold = ZERO_LOW;
         end
         if (p_last == jam_at) begin
            hold = ZERO_LOW;
            jam_at = -1;
         end
      end else if (pull_low) begin
         plen = plen + 1;
      end
      if (!pull_low && prev_low) begin
         if (p_last == 0) start_len = plen;
         else if (((p_last - 1) / 10) < 4) begin
            if (((p_last - 1) % 10) < 8)
               cap[(p_last - 1) / 10][7 - ((p_last - 1) % 10)] = (plen < THRESH);
            else if (((p_last - 1) % 10) == 8)
               cap_eom[(p_last - 1) / 10] = (plen < THRESH);
         end
      end
      if (busy) seen = pcount;
      if (hold > 0) begin
         other_low = 1'b1;
         hold = hold - 1;
      end else begin
         other_low = force_low;
      end
      prev_low = pull_low;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] b, input logic e);
      @(negedge clk); #1;
      tx_byte = b; tx_eom = e; tx_wr = 1'b1;
      @(negedge clk); #1;
      tx_wr = 1'b0; tx_eom = 1'b0;
   endtask

   task automatic start_msg();
      @(negedge clk); #1; cmd_som = 1'b1;
      @(negedge clk); #1; cmd_som = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk); #1; flag_clr = 6'h3F;
      @(negedge clk); #1; flag_clr = 6'h00;
   endtask

   task automatic wait_flags(input logic [5:0] mask, input int maxc);
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk); #1;
         if ((flags & mask) != 0) return;
      end
   endtask

   task automatic settle();
      repeat (60) @(negedge clk);
      #1;
      jam_at = -1; ack_mode = 0;
      clear_all();
      seen = 0; cap_eom = '0;
      for (int k = 0; k < 4; k++) cap[k] = 8'h00;
   endtask

   localparam logic [5:0] TERM = 6'b111100;

   task automatic t_reset();
      chk("R9 reset flags", int'(flags), 0);
      chk("R11 reset pull", int'(pull_low), 0);
      chk("R9 reset busy", int'(busy), 0);
      chk("R9 reset som", int'(som_p), 0);
      chk("R2 reset eom", int'(eom_p), 0);
   endtask

   task automatic t_directed();
      settle(); ack_mode = 1;
      load(8'h40, 1'b0);
      start_msg();
      wait_flags(6'b000010, 2000);
      chk("R3 request after fourth bit", pcount, 6);
      load(8'h36, 1'b1);
      chk("R2 eom pending", int'(eom_p), 1);
      wait_flags(TERM, 2000);
      chk("R9 flags at end", int'(flags), 6'b000110);
      chk("R1 start length", start_len, START_LOW);
      chk("R1 header bits", int'(cap[0]), 8'h40);
      chk("R1 data bits", int'(cap[1]), 8'h36);
      chk("R2 eom bits", int'(cap_eom[1:0]), 2'b10);
      chk("R9 cmds cleared", int'({som_p, eom_p, busy}), 0);
      @(negedge clk); #1; flag_clr = 6'b000010;
      @(negedge clk); #1; flag_clr = 6'b000000;
      chk("R10 one flag cleared", int'(flags), 6'b000100);
   endtask

   task automatic t_header_only();
      settle(); ack_mode = 1;
      load(8'h4A, 1'b1);
      start_msg();
      wait_flags(TERM, 2000);
      chk("R3 no request on last byte", int'(flags), 6'b000100);
      chk("R2 header eom bit", int'(cap_eom[0]), 1);
      chk("R1 header only bits", int'(cap[0]), 8'h4A);
   endtask

   task automatic t_bcast_ok();
      settle(); ack_mode = 0;
      load(8'h4F, 1'b0);
      start_msg();
      wait_flags(6'b000010, 2000);
      load(8'h04, 1'b1);
      wait_flags(TERM, 2000);
      chk("R6 broadcast accepted", int'(flags), 6'b000110);
      chk("R6 broadcast data", int'(cap[1]), 8'h04);
   endtask

   task automatic t_bcast_nack();
      settle(); ack_mode = 2;
      load(8'h4F, 1'b0);
      start_msg();
      wait_flags(6'b000010, 2000);
      load(8'h36, 1'b1);
      wait_flags(TERM, 2000);
      chk("R6 broadcast rejected", int'(flags), 6'b100010);
      chk("R11 cmds cleared on ack error", int'({som_p, eom_p, busy, pull_low}), 0);
   endtask

   task automatic t_no_ack();
      settle(); ack_mode = 0;
      load(8'h45, 1'b1);
      start_msg();
      wait_flags(TERM, 2000);
      chk("R5 missing ack", int'(flags), 6'b100000);
      chk("R5 stopped after header", seen, 11);
      chk("R11 released after ack error", int'({som_p, busy, pull_low}), 0);
   endtask

   task automatic t_underrun();
      settle(); ack_mode = 1;
      load(8'h40, 1'b0);
      start_msg();
      wait_flags(TERM, 2000);
      chk("R4 underrun flags", int'(flags), 6'b001010);
      chk("R4 no byte after header", seen, 11);
      repeat (50) @(negedge clk);
      #1;
      chk("R11 idle after underrun", int'({som_p, busy, pull_low}), 0);
   endtask

   task automatic t_line_err();
      settle(); ack_mode = 1; jam_at = 11;
      load(8'h40, 1'b0);
      start_msg();
      wait_flags(6'b000010, 2000);
      load(8'hFF, 1'b1);
      wait_flags(TERM, 2000);
      chk("R7 line error", int'(flags), 6'b010010);
      chk("R11 cmds cleared on line error", int'({som_p, eom_p, busy}), 0);
   endtask

   task automatic t_arb_wire();
      settle(); ack_mode = 1; jam_at = 2;
      load(8'h40, 1'b1);
      start_msg();
      wait_flags(6'b000001, 2000);
      chk("R8 som kept", int'(som_p), 1);
      chk("R11 released on arbitration loss", int'({busy, pull_low}), 0);
      wait_flags(6'b000100, 3000);
      chk("R8 retry completes", int'(flags), 6'b000101);
      chk("R8 retried header", int'(cap[0]), 8'h40);
   endtask

   task automatic t_arb_idle();
      settle(); ack_mode = 1;
      force_low = 1'b1;
      load(8'h40, 1'b1);
      start_msg();
      repeat (100) @(negedge clk);
      #1;
      chk("R8 earlier starter flag", int'(flags[0]), 1);
      chk("R8 waits without driving", int'({busy, pull_low, som_p}), 1);
      force_low = 1'b0;
      wait_flags(6'b000100, 3000);
      chk("R8 sends after bus frees", int'(flags[2]), 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_directed();
      t_header_only();
      t_bcast_ok();
      t_bcast_nack();
      t_no_ack();
      t_underrun();
      t_line_err();
      t_arb_wire();
      t_arb_idle();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule